// File: doc/BRIEF.md
# Segment Register with Descriptor Cache

This block holds one segment register of an x86-style processor: a visible 16-bit selector and a hidden cache of base, limit and attributes. It also performs the address translation that depends on that cache. A load request carries a new selector. A mode input chooses how the selector is interpreted.

In real mode the hidden cache is computed straight from the selector, with no memory traffic. In protected mode the selector indexes either the global or the local descriptor table. The block reads the 8-byte descriptor through a 32-bit read port in two beats, checks it, and then caches it. A load that fails its checks pulses a fault output and leaves the register as it was.

The translation path is purely combinational. It works only from the cache, so table contents and table registers matter only at load time.

Top module: `seg_reg_unit`

## Requirements
- R1: With `pe_i`=0, an accepted load sets the base to the selector times 16, the limit to 0xFFFF and `db_o` to 0. `load_done_o` is high in the cycle after the load is sampled, and no memory read is issued.
- R2: With `pe_i`=1, selector bits 15:3 are the index, bit 2 selects the local table (1) or the global table (0), and bits 1:0 are the requested privilege. The descriptor is read at table base plus index*8 (low word) and then at that address plus 4 (high word). Each read is held until `mem_ready_i`. `load_done_o` is high in the cycle after the second handshake.
- R3: The 64-bit descriptor is decoded as follows: limit[15:0] in bits 15:0, base[23:0] in bits 39:16, access in bits 47:40, limit[19:16] in bits 51:48, D/B in bit 54, granularity in bit 55, base[31:24] in bits 63:56. `db_o` reflects bit 54.
- R4: With granularity set, the effective limit is limit*4096+0xFFF; with it clear, the limit is the raw 20-bit value.
- R5: `lin_addr_o` = cached base + `off_i` (modulo 2^32). `lim_fault_o` is high exactly when `off_i` exceeds the effective limit.
- R6: A global-table selector with index 0 loads without any memory read and completes one cycle after it is sampled. From then on, `null_fault_o` stays high until the next successful non-null load.
- R7: If index*8+7 exceeds the selected table's byte limit, the load issues no read. `load_fault_o` is high in the cycle after the load is sampled, and the selector and cache keep their previous values.
- R8: If the fetched access byte has bit 7 (present) clear, `load_fault_o` pulses in the cycle after the second handshake and the selector and cache are unchanged.
- R9: After a load, changes to table registers or memory contents do not affect translation until the register is reloaded.
- R10: `load_done_o` and `load_fault_o` are single-cycle pulses and are never high together. A `load_i` while `busy_o` is high is ignored.
- R11: After reset the register is in its real-mode state: selector 0, base 0, limit 0xFFFF, `db_o`=0, no null fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pe_i | input | 1 | 1 selects protected-mode loading |
| load_i | input | 1 | Load request |
| sel_i | input | 16 | Selector to load |
| gdt_base_i | input | 32 | Global table linear base |
| gdt_limit_i | input | 16 | Global table byte limit |
| ldt_base_i | input | 32 | Local table linear base |
| ldt_limit_i | input | 16 | Local table byte limit |
| mem_req_o | output | 1 | Descriptor read valid |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_ready_i | input | 1 | Read accepted, data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Descriptor fetch in progress |
| load_done_o | output | 1 | Load completed pulse |
| load_fault_o | output | 1 | Load rejected pulse |
| sel_o | output | 16 | Visible selector |
| db_o | output | 1 | Cached default-size bit |
| off_i | input | 32 | Offset to translate |
| lin_addr_o | output | 32 | Base plus offset |
| lim_fault_o | output | 1 | Offset beyond limit |
| null_fault_o | output | 1 | Register holds the null selector |

## Verification
The following loads produce their completion or fault pulse exactly one cycle after the request is sampled:
- real-mode loads
- null-selector loads
- loads rejected by a table limit

Protected-mode loads that fetch a descriptor produce their pulse in the cycle after the second read handshake. With the bench's memory answering each read one cycle after the request, that is four cycles after the load.

The bench counts cycles from the request and checks the pulse in the exact cycle. It also counts cycles with a read request open, to confirm that loads without a fetch issue none. Translation results are combinational from the cache and are sampled half a cycle after the offset is driven, once the load has finished.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic        db;
    logic        nul;
  } seg_cache_t;

  localparam logic [31:0] REAL_LIMIT = 32'h0000_FFFF;

  function automatic seg_cache_t decode_desc(input logic [63:0] d);
    seg_cache_t c;
    logic [19:0] raw;
    raw     = {d[51:48], d[15:0]};
    c.base  = {d[63:56], d[39:16]};
    c.limit = d[55] ? {raw, 12'hFFF} : {12'h000, raw};
    c.db    = d[54];
    c.nul   = 1'b0;
    return c;
  endfunction

  function automatic seg_cache_t real_cache(input logic [15:0] sel);
    seg_cache_t c;
    c.base  = {12'h000, sel, 4'h0};
    c.limit = REAL_LIMIT;
    c.db    = 1'b0;
    c.nul   = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_ready_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] desc_o
);
  localparam logic [ADDR_W-1:0] BEAT = ADDR_W'(DATA_W / 8);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;
  fst_e              st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          st_q   <= F_LO;
          addr_q <= addr_i;
        end
        F_LO: if (mem_ready_i) begin
          st_q   <= F_HI;
          lo_q   <= mem_rdata_i;
          addr_q <= addr_q + BEAT;
        end
        F_HI: if (mem_ready_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q != F_IDLE);
  assign mem_addr_o = addr_q;
  assign busy_o     = mem_req_o;
  assign done_o     = (st_q == F_HI) && mem_ready_i;
  assign desc_o     = {mem_rdata_i, lo_q};

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_second_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_LO && mem_ready_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + BEAT));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  seg_cache_t  cache_i,
  input  logic [31:0] off_i,
  output logic [31:0] lin_addr_o,
  output logic        lim_fault_o,
  output logic        null_fault_o
);
  always_comb begin
    lin_addr_o   = cache_i.base + off_i;
    lim_fault_o  = off_i > cache_i.limit;
    null_fault_o = cache_i.nul;
  end
endmodule

// File: rtl/seg_reg_unit.sv
module seg_reg_unit
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pe_i,
  input  logic              load_i,
  input  logic [15:0]       sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [15:0]       gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [15:0]       ldt_limit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              load_done_o,
  output logic              load_fault_o,
  output logic [15:0]       sel_o,
  output logic              db_o,
  input  logic [31:0]       off_i,
  output logic [31:0]       lin_addr_o,
  output logic              lim_fault_o,
  output logic              null_fault_o
);
  localparam int IDX_W = 13;

  seg_cache_t        cache_q;
  logic [15:0]       sel_q, pend_q;
  logic              done_q, fault_q;
  logic              accept, use_ldt, is_null, over_lim, start;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tbl_base, fetch_addr, last_byte, tbl_lim;
  logic              f_done;
  logic [63:0]       desc;

  assign accept     = load_i && !busy_o;
  assign idx        = sel_i[15:3];
  assign use_ldt    = sel_i[2];
  assign is_null    = !use_ldt && (idx == '0);
  assign tbl_base   = use_ldt ? ldt_base_i : gdt_base_i;
  assign tbl_lim    = ADDR_W'(use_ldt ? ldt_limit_i : gdt_limit_i);
  assign last_byte  = ADDR_W'({idx, 3'b111});
  assign over_lim   = last_byte > tbl_lim;
  assign fetch_addr = tbl_base + ADDR_W'({idx, 3'b000});
  assign start      = accept && pe_i && !is_null && !over_lim;

  seg_fetch #(.ADDR_W(ADDR_W), .DATA_W(32)) i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .addr_i      (fetch_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (f_done),
    .desc_o      (desc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cache_q <= real_cache(16'h0000);
      sel_q   <= '0;
      pend_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        if (!pe_i) begin
          cache_q <= real_cache(sel_i);
          sel_q   <= sel_i;
          done_q  <= 1'b1;
        end else if (is_null) begin
          cache_q <= '{base: '0, limit: '0, db: 1'b0, nul: 1'b1};
          sel_q   <= sel_i;
          done_q  <= 1'b1;
        end else if (over_lim) begin
          fault_q <= 1'b1;
        end else begin
          pend_q  <= sel_i;
        end
      end
      if (f_done) begin
        if (desc[47]) begin
          cache_q <= decode_desc(desc);
          sel_q   <= pend_q;
          done_q  <= 1'b1;
        end else begin
          fault_q <= 1'b1;
        end
      end
    end
  end

  seg_xlate i_xlate (
    .cache_i      (cache_q),
    .off_i        (off_i),
    .lin_addr_o   (lin_addr_o),
    .lim_fault_o  (lim_fault_o),
    .null_fault_o (null_fault_o)
  );

  assign load_done_o  = done_q;
  assign load_fault_o = fault_q;
  assign sel_o        = sel_q;
  assign db_o         = cache_q.db;

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> !load_done_o);
  assert_done_fault_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_done_o && load_fault_o));
  assert_real_no_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && !pe_i) |=> (!mem_req_o && load_done_o));
  assert_fault_keeps_cache_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fault_o |-> ($stable(lin_addr_o) || !$stable(off_i)) && $stable(sel_o));
endmodule

// File: tb/test_seg_reg_unit.sv
module test_seg_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe = 1'b0, load = 1'b0, ready = 1'b0;
  logic [15:0] sel = '0, gdt_lim = 16'h002F, ldt_lim = 16'h000F;
  logic [31:0] gdt_base = 32'h1000, ldt_base = 32'h2000, rdata = '0, off = '0;
  logic        mem_req, busy, done, fault, db, lim_f, null_f;
  logic [31:0] mem_addr, lin;
  logic [15:0] sel_out;
  logic        alt = 1'b0;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  seg_reg_unit i_seg_reg_unit (
    .clk_i(clk), .rst_ni(rst_n), .pe_i(pe), .load_i(load), .sel_i(sel),
    .gdt_base_i(gdt_base), .gdt_limit_i(gdt_lim), .ldt_base_i(ldt_base),
    .ldt_limit_i(ldt_lim), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(ready), .mem_rdata_i(rdata), .busy_o(busy),
    .load_done_o(done), .load_fault_o(fault), .sel_o(sel_out), .db_o(db),
    .off_i(off), .lin_addr_o(lin), .lim_fault_o(lim_f), .null_fault_o(null_f)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic al);
    case (a)
      32'h1008: return 32'h0000FFFF;
      32'h100C: return 32'h00CF9A00;
      32'h1010: return al ? 32'h0 : 32'h56780010;
      32'h1014: return al ? 32'h0 : 32'h12009234;
      32'h1018: return 32'h0000FFFF;
      32'h101C: return 32'h00001200;
      32'h1020: return 32'h00000003;
      32'h1024: return 32'h00809240;
      32'h2008: return 32'h0000FFFF;
      32'h200C: return 32'hAB4092CD;
      32'h5010: return 32'h010000FF;
      32'h5014: return 32'h00409200;
      default:  return 32'h0;
    endcase
  endfunction

  // memory responder: ready one cycle after each request, data from address
  initial forever begin
    @(negedge clk);
    ready = mem_req && !ready;
    rdata = mem_word(mem_addr, alt);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int lat, reads;
  logic got_done, got_fault;

  // drives a load at a negedge, returns cycles until the pulse
  task automatic do_load(input logic p, input logic [15:0] s);
    @(negedge clk);
    pe = p; sel = s; load = 1'b1;
    lat = 0; reads = 0; got_done = 0; got_fault = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      load = 1'b0;
      lat++;
      if (mem_req) reads++;
      if (done || fault) begin
        got_done = done; got_fault = fault;
        break;
      end
    end
  endtask

  localparam int NV = 14;
  localparam logic        V_PE  [NV] = '{0,0,1,1,1,1,1,1,1,1,1,1,1,0};
  localparam logic [15:0] V_SEL [NV] = '{16'h1234,16'hF000,16'h0008,16'h0010,16'h0010,16'h0020,
    16'h0020,16'h0018,16'h0030,16'h000F,16'h0014,16'h0004,16'h0003,16'h0000};
  localparam logic [31:0] V_OFF [NV] = '{32'h10,32'h10000,32'hFFFFFFFF,32'h10,32'h11,32'h3FFF,
    32'h4000,32'h10,32'h4001,32'hFFFF,32'h10000,32'h0,32'h0,32'hFFFF};
  localparam logic        V_FLT [NV] = '{0,0,0,0,0,0,0,1,1,0,1,1,0,0};
  localparam int          V_LAT [NV] = '{1,1,4,4,4,4,4,4,1,4,1,4,1,1};
  localparam logic [31:0] V_LIN [NV] = '{32'h12350,32'h100000,32'hFFFFFFFF,32'h12345688,
    32'h12345689,32'h00403FFF,32'h00404000,32'h00400010,32'h00404001,32'hABCDFFFF,
    32'hABCE0000,32'hABCD0000,32'h0,32'hFFFF};
  localparam logic        V_LF  [NV] = '{0,1,0,0,1,0,1,0,1,0,1,0,0,0};
  localparam logic        V_DB  [NV] = '{0,0,1,0,0,0,0,0,0,1,1,1,0,0};
  localparam logic        V_NUL [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,0};

  initial begin
    logic [15:0] exp_sel;
    exp_sel = 16'h0;
    off = 32'h1234;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 sel", {16'h0, sel_out}, 32'h0);
    check("R11 lin", lin, 32'h1234);
    check("R11 flags", {29'h0, db, lim_f, null_f}, 32'h0);
    check("R11 idle", {29'h0, mem_req, done, fault}, 32'h0);
    rst_n = 1'b1;

    // R1..R8 vector walk
    for (int v = 0; v < NV; v++) begin
      do_load(V_PE[v], V_SEL[v]);
      check($sformatf("R2 R7 R8 v%0d latency", v), lat, V_LAT[v]);
      check($sformatf("R7 R8 v%0d kind", v), {30'h0, got_fault, got_done}, {30'h0, V_FLT[v], !V_FLT[v]});
      if (V_LAT[v] == 1) check($sformatf("R1 R6 R7 v%0d no read", v), reads, 0);
      else check($sformatf("R2 v%0d two reads", v), reads, 3);
      if (!V_FLT[v]) exp_sel = V_SEL[v];
      @(negedge clk);
      check($sformatf("R10 v%0d pulse end", v), {30'h0, done, fault}, 32'h0);
      off = V_OFF[v];
      #1;
      check($sformatf("R3 R4 R5 v%0d lin", v), lin, V_LIN[v]);
      check($sformatf("R4 R5 v%0d lim", v), {31'h0, lim_f}, {31'h0, V_LF[v]});
      check($sformatf("R3 v%0d db", v), {31'h0, db}, {31'h0, V_DB[v]});
      check($sformatf("R6 v%0d null", v), {31'h0, null_f}, {31'h0, V_NUL[v]});
      check($sformatf("R7 R8 v%0d sel", v), {16'h0, sel_out}, {16'h0, exp_sel});
    end

    // R9: cache isolation
    do_load(1'b1, 16'h0010);
    @(negedge clk);
    alt = 1'b1; gdt_base = 32'h5000; off = 32'h4;
    repeat (2) @(negedge clk);
    check("R9 hold lin", lin, 32'h1234567C);
    do_load(1'b1, 16'h0010);
    @(negedge clk);
    check("R9 reload lin", lin, 32'h104);
    check("R9 reload db", {31'h0, db}, 32'h1);

    // R10: load while busy ignored
    gdt_base = 32'h1000; alt = 1'b0;
    @(negedge clk);
    pe = 1'b1; sel = 16'h0008; load = 1'b1;
    @(negedge clk);
    pe = 1'b0; sel = 16'h1234;
    @(negedge clk);
    load = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 ignored sel", {16'h0, sel_out}, 32'h0008);
    check("R10 ignored db", {31'h0, db}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule